// File: doc/BRIEF.md
# Buffered Serial Transmitter with Break and Preamble

The block turns parallel words into asynchronous serial frames on a single output line. A host places a word in a one-entry holding register. At the next bit-rate tick the word moves into a shift register, and the holding register is free again. Each frame is a low start bit, then 8 or 9 payload bits sent least significant bit first, then a high stop bit. Parity is optional. When it is on, the highest payload bit is replaced by a generated even or odd parity bit.

When the enable input rises, the block first sends a preamble of all-ones bit times. While the break request is held, it sends back-to-back break characters made only of zeros; a break character can be normal or long. After the last break character it always drives one high bit before any queued frame. Clearing the enable mid-frame lets that frame finish before the line rests high. Two flags report the state of the block: holding-register empty, and all-done. Each flag has its own interrupt request, which its enable gates.

The sequencer has five states:
- `ST_IDLE` (line high) moves on a tick to the choice made by the picker. The picker checks, in priority order: preamble pending → `ST_PRE`, break request → `ST_BRK`, word waiting → `ST_DATA`, otherwise stay.
- `ST_PRE` (preamble ones) and `ST_DATA` (frame bits) return to the picker after their last bit.
- `ST_BRK` (zeros) restarts itself while the break request and the enable remain high. Otherwise it goes to `ST_BRKEND`.
- `ST_BRKEND` (one high bit) returns to the picker.
- With the enable low, the picker always selects `ST_IDLE`.

Top module: `async_brk_tx`

## Requirements
- R1: A frame is a 0 start bit, then the payload LSB first, then a 1 stop bit. `wide_fmt`=0 sends 8 payload bits (`wr_data[7:0]`, 10 bit times). `wide_fmt`=1 sends 9 payload bits (`wr_data[8:0]`, 11 bit times).
- R2: With `par_en`=1, the last payload bit (bit 7 narrow, bit 8 wide) is replaced by a parity bit. That bit makes the count of ones over the sent payload even when `par_odd`=0, and odd when `par_odd`=1.
- R3: `tx_empty` falls on an accepted write and rises on the clock edge where the word moves into the shift register. A write strobe while `tx_empty`=0 is ignored and leaves the queued word unchanged.
- R4: `tx_done` is 1 only when the holding register is empty and the sequencer is idle. It is 0 during preamble, frame, break and the post-break high bit.
- R5: After reset, `txd`=1, `tx_empty`=1 and `tx_done`=1.
- R6: On each rising edge of `tx_en`, a preamble of 8 (narrow) or 9 (wide) high bit times is sent before any frame or break.
- R7: While `brk_req` and `tx_en` are 1, break characters of zeros are sent back to back. A character is 10/11 bits (narrow/wide) with `brk_long`=0, and 13/14 bits with `brk_long`=1.
- R8: After the last break character, at least one high bit time is driven before a queued frame starts.
- R9: When `tx_en` falls during a frame, the frame completes and `txd` then stays 1. No queued word is sent while `tx_en` is 0.
- R10: `irq_empty` = `irq_empty_en` AND `tx_empty`, and `irq_done` = `irq_done_en` AND `tx_done`.
- R11: `txd` and the sequencer state change only on clock edges where `bit_tick` is 1. Mode inputs are sampled when a frame or character starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Hold high to send break characters |
| wide_fmt | input | 1 | 0: 8 payload bits, 1: 9 payload bits |
| par_en | input | 1 | Replace last payload bit by parity |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| brk_long | input | 1 | Select the longer break character |
| irq_empty_en | input | 1 | Enable for the empty interrupt |
| irq_done_en | input | 1 | Enable for the done interrupt |
| txd | output | 1 | Serial line, idle high |
| tx_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Nothing queued and nothing being sent |
| irq_empty | output | 1 | Empty interrupt request |
| irq_done | output | 1 | Done interrupt request |

## Verification
The assertions assume that `bit_tick` is a single-cycle pulse and that all inputs are synchronous to `clk`. The stimulus drives every input half a cycle away from the active edge. It generates `bit_tick` as one pulse every four cycles. It changes the format and parity inputs only while no word waits for a tick, or in deliberate cases that the reference model samples at the same load edge as the design. Writes while the holding register is full are issued on purpose, to show that they are ignored.

// File: rtl/atx_pkg.sv
package atx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_BRK,
        ST_BRKEND
    } atx_state_e;
endpackage

// File: rtl/atx_hold.sv
module atx_hold #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full      <= 1'b0;
            hold_data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_stb && !full) begin
            full      <= 1'b1;
            hold_data <= wr_data;
        end
    end

    // R3: shift register only takes a word that is really queued
    a_r3_take_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);

    // R3: a write into a full register leaves the word untouched
    a_r3_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && full && !take) |=> $stable(hold_data));
endmodule

// File: rtl/atx_framer.sv
module atx_framer #(
    parameter int DATA_W = 9
) (
    input  logic [DATA_W-1:0] data,
    input  logic              wide,
    input  logic              par_en,
    input  logic              par_odd,
    output logic [DATA_W+1:0] word
);
    localparam int NARROW_W = DATA_W - 1;

    logic [DATA_W-1:0] payload;
    logic              par_bit;

    always_comb begin
        payload = data;
        par_bit = par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (wide ? (i < DATA_W - 1) : (i < NARROW_W - 1)) begin
                par_bit = par_bit ^ data[i];
            end
        end
        if (par_en) begin
            if (wide) payload[DATA_W-1] = par_bit;
            else      payload[NARROW_W-1] = par_bit;
        end
        if (!wide) begin
            payload[DATA_W-1] = 1'b1;
        end
        word = {1'b1, payload, 1'b0};
    end
endmodule

// File: rtl/atx_seq.sv
module atx_seq
    import atx_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter int BRK_EXTRA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              wide,
    input  logic              brk_long,
    input  logic              buf_full,
    input  logic [DATA_W+1:0] frame_word,
    output logic              take,
    output logic              txd,
    output logic              line_idle
);
    localparam int SH_W    = DATA_W + 2;
    localparam int BRK_MAX = SH_W + BRK_EXTRA;
    localparam int CNT_W   = $clog2(BRK_MAX + 1);
    localparam logic [CNT_W-1:0] PRE_WIDE   = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] PRE_NARROW = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] FRM_WIDE   = CNT_W'(SH_W);
    localparam logic [CNT_W-1:0] FRM_NARROW = CNT_W'(SH_W - 1);
    localparam logic [CNT_W-1:0] BRK_ADD    = CNT_W'(BRK_EXTRA);
    localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

    atx_state_e       state, st_n, pick_st;
    logic [CNT_W-1:0] cnt, cnt_n, pick_cnt, brk_len;
    logic [SH_W-1:0]  shreg, sh_n;
    logic             te_q, pre_pend, pre_clr;
    logic             pick_load, pick_pre, use_pick;

    // picker: what starts when the line is free
    always_comb begin
        brk_len   = (wide ? FRM_WIDE : FRM_NARROW) + (brk_long ? BRK_ADD : '0);
        pick_st   = ST_IDLE;
        pick_cnt  = '0;
        pick_load = 1'b0;
        pick_pre  = 1'b0;
        if (tx_en) begin
            if (pre_pend) begin
                pick_st  = ST_PRE;
                pick_cnt = wide ? PRE_WIDE : PRE_NARROW;
                pick_pre = 1'b1;
            end else if (brk_req) begin
                pick_st  = ST_BRK;
                pick_cnt = brk_len;
            end else if (buf_full) begin
                pick_st   = ST_DATA;
                pick_cnt  = wide ? FRM_WIDE : FRM_NARROW;
                pick_load = 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        st_n     = state;
        cnt_n    = cnt;
        sh_n     = shreg;
        use_pick = 1'b0;
        take     = 1'b0;
        pre_clr  = 1'b0;
        if (bit_tick) begin
            unique case (state)
                ST_IDLE, ST_BRKEND: use_pick = 1'b1;
                ST_PRE: begin
                    if (cnt == ONE) use_pick = 1'b1;
                    else            cnt_n = cnt - ONE;
                end
                ST_DATA: begin
                    if (cnt == ONE) begin
                        use_pick = 1'b1;
                    end else begin
                        cnt_n = cnt - ONE;
                        sh_n  = {1'b1, shreg[SH_W-1:1]};
                    end
                end
                ST_BRK: begin
                    if (cnt != ONE) begin
                        cnt_n = cnt - ONE;
                    end else if (tx_en && brk_req) begin
                        cnt_n = brk_len;
                    end else begin
                        st_n  = ST_BRKEND;
                        cnt_n = ONE;
                    end
                end
                default: st_n = ST_IDLE;
            endcase
            if (use_pick) begin
                st_n    = pick_st;
                cnt_n   = pick_cnt;
                pre_clr = pick_pre;
                if (pick_load) begin
                    sh_n = frame_word;
                    take = 1'b1;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '1;
            te_q     <= 1'b0;
            pre_pend <= 1'b0;
        end else begin
            state <= st_n;
            cnt   <= cnt_n;
            shreg <= sh_n;
            te_q  <= tx_en;
            if (pre_clr)         pre_pend <= 1'b0;
            if (tx_en && !te_q)  pre_pend <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_DATA: txd = shreg[0];
            ST_BRK:  txd = 1'b0;
            default: txd = 1'b1;
        endcase
        line_idle = (state == ST_IDLE);
    end

    // R11: the line only moves on a tick
    a_r11_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(txd));

    // R1: a loaded frame opens with the low start bit
    a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (txd == 1'b0));

    // R8: leaving a break always passes through the high bit
    a_r8_high_after_break: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_BRK && state != ST_BRK) |-> (state == ST_BRKEND && txd));

    // R9: with the enable low an idle line stays idle
    a_r9_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && state == ST_IDLE) |=> (state == ST_IDLE));
endmodule

// File: rtl/async_brk_tx.sv
module async_brk_tx #(
    parameter int DATA_W    = 9,
    parameter int BRK_EXTRA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              wide_fmt,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              brk_long,
    input  logic              irq_empty_en,
    input  logic              irq_done_en,
    output logic              txd,
    output logic              tx_empty,
    output logic              tx_done,
    output logic              irq_empty,
    output logic              irq_done
);
    localparam int SH_W = DATA_W + 2;

    logic [DATA_W-1:0] hold_data;
    logic [SH_W-1:0]   frame_word;
    logic              full, take, line_idle;

    atx_hold #(.DATA_W(DATA_W)) hold_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .take(take), .hold_data(hold_data), .full(full)
    );

    atx_framer #(.DATA_W(DATA_W)) framer_i (
        .data(hold_data), .wide(wide_fmt), .par_en(par_en),
        .par_odd(par_odd), .word(frame_word)
    );

    atx_seq #(.DATA_W(DATA_W), .BRK_EXTRA(BRK_EXTRA)) seq_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
        .brk_req(brk_req), .wide(wide_fmt), .brk_long(brk_long),
        .buf_full(full), .frame_word(frame_word), .take(take),
        .txd(txd), .line_idle(line_idle)
    );

    assign tx_empty  = !full;
    assign tx_done   = !full && line_idle;
    assign irq_empty = irq_empty_en && tx_empty;
    assign irq_done  = irq_done_en && tx_done;

    // R4: done implies the holding register is empty
    a_r4_done_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> tx_empty);

    // R3: an accepted write clears the empty flag on the next cycle
    a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tx_empty) |=> !tx_empty);
endmodule

// File: tb/async_brk_tx_tb_top.sv
module async_brk_tx_tb_top;
    localparam int CLK_NS   = 10;
    localparam int TICK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tx_en = 1'b0, brk_req = 1'b0, wide_fmt = 1'b0;
    logic       par_en = 1'b0, par_odd = 1'b0, brk_long = 1'b0;
    logic       irq_empty_en = 1'b0, irq_done_en = 1'b0;
    logic       txd, tx_empty, tx_done, irq_empty, irq_done;

    async_brk_tx dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_stb(wr_stb),
        .wr_data(wr_data), .tx_en(tx_en), .brk_req(brk_req),
        .wide_fmt(wide_fmt), .par_en(par_en), .par_odd(par_odd),
        .brk_long(brk_long), .irq_empty_en(irq_empty_en),
        .irq_done_en(irq_done_en), .txd(txd), .tx_empty(tx_empty),
        .tx_done(tx_done), .irq_empty(irq_empty), .irq_done(irq_done)
    );

    always #(CLK_NS/2) clk = ~clk;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R5";

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // reference model: queue of pending line bits
    bit       mq[$];
    int       mkind = 0;   // 0 idle,1 preamble,2 frame,3 break,4 post-break high
    bit       mfull = 0, mpend = 0, mte_q = 0, exp_txd = 1, last_tick = 1;
    bit [8:0] mdata = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            mkind = 0; mfull = 0; mpend = 0; mte_q = 0; exp_txd = 1;
        end else begin
            bit old_full;
            old_full = mfull;
            if (bit_tick) begin
                if (mq.size() == 0) begin
                    if (mkind == 3 && tx_en && brk_req) begin
                        for (int i = 0; i < (wide_fmt ? 11 : 10) + (brk_long ? 3 : 0); i++) mq.push_back(1'b0);
                    end else if (mkind == 3) begin
                        mq.push_back(1'b1); mkind = 4;
                    end else if (!tx_en) begin
                        mkind = 0;
                    end else if (mpend) begin
                        for (int i = 0; i < (wide_fmt ? 9 : 8); i++) mq.push_back(1'b1);
                        mkind = 1; mpend = 0;
                    end else if (brk_req) begin
                        for (int i = 0; i < (wide_fmt ? 11 : 10) + (brk_long ? 3 : 0); i++) mq.push_back(1'b0);
                        mkind = 3;
                    end else if (mfull) begin
                        int  nb;
                        bit  p;
                        bit [8:0] d;
                        nb = wide_fmt ? 9 : 8;
                        d  = mdata;
                        p  = par_odd;
                        for (int i = 0; i < nb - 1; i++) p ^= d[i];
                        if (par_en) d[nb-1] = p;
                        mq.push_back(1'b0);
                        for (int i = 0; i < nb; i++) mq.push_back(d[i]);
                        mq.push_back(1'b1);
                        mfull = 0; mkind = 2;
                    end else begin
                        mkind = 0;
                    end
                end
                exp_txd = (mq.size() > 0) ? mq.pop_front() : 1'b1;
            end
            if (wr_stb && !old_full) begin
                mfull = 1; mdata = wr_data;
            end
            if (tx_en && !mte_q) mpend = 1;
            mte_q = tx_en;
        end
        last_tick = bit_tick;
    end

    // tick generator
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            bit_tick = (ph == 0);
            ph = (ph + 1) % TICK_DIV;
        end
    end

    // per-cycle comparison, away from both edges
    bit prev_txd = 1;
    bit have_prev = 0;
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_NS/4);
            if (rst_n) begin
                bit etc;
                etc = (mkind == 0) && !mfull;
                chk(cur_req, "txd", txd, exp_txd);
                chk("R3", "tx_empty", tx_empty, !mfull);
                chk("R4", "tx_done", tx_done, etc);
                chk("R10", "irq_empty", irq_empty, irq_empty_en && !mfull);
                chk("R10", "irq_done", irq_done, irq_done_en && etc);
                if (have_prev && !last_tick) chk("R11", "txd between ticks", txd, prev_txd);
                prev_txd = txd;
                have_prev = 1;
            end
        end
    end

    task automatic put(input logic [8:0] d);
        int guard;
        guard = 0;
        @(negedge clk);
        while (!tx_empty && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        wr_stb = 1'b1; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        @(negedge clk);
        while (!(tx_done && mkind == 0) && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TICK_DIV) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #(CLK_NS/4);
        chk("R5", "txd after reset", txd, 1);
        chk("R5", "tx_empty after reset", tx_empty, 1);
        chk("R5", "tx_done after reset", tx_done, 1);

        cur_req = "R6";                 // preamble on enable
        tx_en = 1'b1;
        wait_ticks(3);
        chk("R6", "tx_done during preamble", tx_done, 0);
        wait_idle();

        cur_req = "R1";                 // narrow frames, back to back
        put(9'h067);
        #(CLK_NS/4);
        chk("R4", "tx_done with word queued", tx_done, 0);
        put(9'h0A5);
        cur_req = "R3";                 // write into full register ignored
        @(negedge clk);
        #(CLK_NS/4);
        chk("R3", "tx_empty before extra write", tx_empty, 0);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = 9'h13C;
        @(negedge clk);
        wr_stb = 1'b0;
        wait_idle();
        chk("R4", "tx_done when idle", tx_done, 1);

        cur_req = "R1";                 // wide frames
        wide_fmt = 1'b1;
        put(9'h1A5);
        put(9'h0FF);
        wait_idle();

        cur_req = "R2";                 // parity in both widths
        par_en = 1'b1;
        wide_fmt = 1'b0; par_odd = 1'b0; put(9'h067); wait_idle();
        par_odd = 1'b1; put(9'h067); wait_idle();
        wide_fmt = 1'b1; par_odd = 1'b0; put(9'h155); wait_idle();
        par_odd = 1'b1; put(9'h0F0); wait_idle();
        par_en = 1'b0;

        cur_req = "R7";                 // normal breaks, queued frame behind
        wide_fmt = 1'b0; brk_long = 1'b0;
        @(negedge clk);
        brk_req = 1'b1;
        put(9'h081);
        wait_ticks(25);
        #(CLK_NS/4);
        chk("R7", "tx_done during break", tx_done, 0);
        @(negedge clk);
        brk_req = 1'b0;
        cur_req = "R8";
        wait_idle();

        cur_req = "R7";                 // long breaks, wide
        wide_fmt = 1'b1; brk_long = 1'b1;
        @(negedge clk);
        brk_req = 1'b1;
        wait_ticks(31);
        brk_req = 1'b0;
        cur_req = "R8";
        put(9'h12E);
        wait_idle();
        brk_long = 1'b0;

        cur_req = "R9";                 // enable dropped mid-frame
        wide_fmt = 1'b0;
        put(9'h00F);
        wait_ticks(4);
        tx_en = 1'b0;
        put(9'h033);
        wait_ticks(20);
        #(CLK_NS/4);
        chk("R9", "line high with enable low", txd, 1);
        chk("R9", "word still queued", tx_empty, 0);
        @(negedge clk);
        cur_req = "R6";
        tx_en = 1'b1;
        wait_idle();

        cur_req = "R10";                // interrupt gating
        irq_empty_en = 1'b1; irq_done_en = 1'b1;
        @(negedge clk);
        #(CLK_NS/4);
        chk("R10", "irq_done when idle", irq_done, 1);
        put(9'h05A);
        #(CLK_NS/4);
        chk("R10", "irq_empty with word queued", irq_empty, 0);
        wait_idle();
        irq_empty_en = 1'b0;
        put(9'h0C3);
        wait_idle();
        irq_done_en = 1'b0;
        wait_ticks(2);

        finish_run();
    end
endmodule